// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block sits in front of a cache maintenance sequencer. It takes one request for a byte range: a start address, an end address that is not itself included, and an operation (invalidate, clean or flush). It turns that request into a series of hardware commands, each with an inclusive line-aligned start and end. A command is either a single-line clean-and-invalidate, a clean over a range or an invalidate over a range. Commands leave on a valid/ready interface one at a time. After the sequencer has accepted the last one, the block pulses `done`.

Three limits shape the ranges. Each range is aligned to cache lines. It covers no more than a fixed number of bytes. It never crosses a page boundary. For an invalidate, a line that the request covers only in part is not thrown away. It is cleaned and invalidated as a single line, and only the fully covered lines are invalidated as ranges. For clean and flush the range is widened outward to whole lines. When the write-through override is set, the cache can hold no dirty data, so all clean work is dropped.

The block handles one request at a time and refuses new requests until the current one is finished. Requests are expected to satisfy start <= end, and the end rounded up to a line must stay inside the address space.

Top module: `rsplit_top`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, and `cmd_valid` and `done` are 0.
- R2: Op codes are 0 = invalidate, 1 = clean, 2 = flush (3 behaves as flush). Command kinds are 0 = single-line clean-and-invalidate, 1 = clean range, 2 = invalidate range. For a single-line command, `cmd_start` equals `cmd_end`, and both are the line address.
- R3: Each range command has a line-aligned `cmd_start`. Its `cmd_end` equals the exclusive end of the chunk minus one line (LINE_BYTES = 32), so it is inclusive and line-aligned.
- R4: No range command covers more than MAX_BYTES (1024) bytes. The next chunk starts right after the previous chunk's end.
- R5: No range command crosses a PAGE_BYTES (4096) page boundary. A chunk end is clipped to the start of the next page.
- R6: Invalidate, start not line-aligned: the first command is a single-line clean-and-invalidate of the line holding the start. The ranges then begin at the next line boundary.
- R7: Invalidate, end not line-aligned, and the advanced start still below the end: a single-line clean-and-invalidate of the line holding the end follows. The ranges then stop at the end rounded down to a line.
- R8: Clean and flush round the start down and the end up to line boundaries before chunking.
- R9: Flush emits, for each chunk, a clean range and then an invalidate range with the same start and end.
- R10: The override level is sampled when a request is accepted. With it set, clean emits no commands and flush emits only its invalidate ranges.
- R11: `done` is high for exactly one cycle: the cycle after the last command is accepted. If there is no command, it is the cycle after the request is accepted.
- R12: `req_ready` is low from the acceptance of a request until `done`. A request offered during that time is ignored.
- R13: While `cmd_valid` is high and `cmd_ready` is low, the command fields do not change and `cmd_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_start | input | ADDR_W | First byte of range |
| req_end | input | ADDR_W | Byte after last byte of range |
| req_op | input | 2 | Operation code (R2) |
| wt_override | input | 1 | Write-through override, drops clean work |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sequencer takes command |
| cmd_kind | output | 2 | Command kind (R2) |
| cmd_start | output | ADDR_W | Inclusive first line address |
| cmd_end | output | ADDR_W | Inclusive last line address |
| done | output | 1 | One-cycle pulse when request finished |

## Verification
The bench uses the default parameters: 32-bit addresses, 32-byte lines, 1024-byte chunks and 4096-byte pages. Because the chunk limit is a quarter of a page, one run hits both limits. Ranges that start on a page are cut by the byte limit, ranges that start near the end of a page are cut by the page edge, and one 12 KiB clean walks through both many times. Unaligned starts and ends, single-line and empty requests, the override, and stalls on the command side check the edge-line handling, flush ordering, stability under backpressure and the timing of the done pulse.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
  typedef enum logic [1:0] {
    OP_INV   = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_FLUSH_ALT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    K_LINE  = 2'd0,
    K_CLEAN = 2'd1,
    K_INV   = 2'd2
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HEAD = 3'd1,
    S_TAIL = 3'd2,
    S_CLN  = 3'd3,
    S_INV  = 3'd4,
    S_DONE = 3'd5
  } st_e;
endpackage

// File: rtl/rsplit_align.sv
module rsplit_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  rsplit_pkg::op_e   op_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic [ADDR_W-1:0] lim_o,
  output logic              head_o,
  output logic              tail_o
);
  import rsplit_pkg::*;

  localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE  = ADDR_W'(LINE_BYTES);

  logic              s_part, e_part;
  logic [ADDR_W-1:0] s_dn, e_dn, s_up, e_up;

  always_comb begin
    s_part = |(start_i & LMASK);
    e_part = |(end_i & LMASK);
    s_dn   = start_i & ~LMASK;
    e_dn   = end_i & ~LMASK;
    s_up   = s_part ? (s_dn + LINE) : s_dn;
    e_up   = e_part ? (e_dn + LINE) : e_dn;
    if (op_i == OP_INV) begin
      cur_o  = s_up;
      lim_o  = e_dn;
      head_o = s_part;
      tail_o = (s_up < end_i) && e_part;
    end else begin
      cur_o  = s_dn;
      lim_o  = e_up;
      head_o = 1'b0;
      tail_o = 1'b0;
    end
  end
endmodule

// File: rtl/rsplit_chunk.sv
module rsplit_chunk #(
  parameter int ADDR_W     = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] lim_i,
  output logic [ADDR_W-1:0] chunk_end_o
);
  localparam int WW = ADDR_W + 1;
  localparam logic [ADDR_W-1:0] PMASK = ADDR_W'(PAGE_BYTES - 1);

  logic [WW-1:0] cap_w, pg_w, lim_w, pick_w;

  always_comb begin
    cap_w  = {1'b0, cur_i} + WW'(MAX_BYTES);
    pg_w   = {1'b0, cur_i | PMASK} + WW'(1);
    lim_w  = {1'b0, lim_i};
    pick_w = lim_w;
    if (cap_w < pick_w) pick_w = cap_w;
    if (pg_w < pick_w)  pick_w = pg_w;
    chunk_end_o = pick_w[ADDR_W-1:0];
  end

  // R4
  chunk_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_i < lim_i) |-> (chunk_end_o > cur_i) && (chunk_end_o <= lim_i));
endmodule

// File: rtl/rsplit_top.sv
module rsplit_top #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_BYTES  = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic [1:0]        req_op,
  input  logic              wt_override,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_start,
  output logic [ADDR_W-1:0] cmd_end,
  output logic              done
);
  import rsplit_pkg::*;

  localparam int PSH = $clog2(PAGE_BYTES);
  localparam int LSB = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE = ADDR_W'(LINE_BYTES);

  st_e               state_q, state_nx;
  logic [ADDR_W-1:0] cur_q, cur_nx, lim_q, lim_nx;
  op_e               op_q, op_nx;
  logic              wt_q, wt_nx, tail_q, tail_nx;
  logic              take, upd_en;

  op_e               in_op;
  logic [ADDR_W-1:0] al_cur, al_lim, chunk_end;
  logic              al_head, al_tail;

  assign in_op = op_e'(req_op);

  rsplit_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .start_i(req_start), .end_i(req_end), .op_i(in_op),
    .cur_o(al_cur), .lim_o(al_lim), .head_o(al_head), .tail_o(al_tail)
  );

  rsplit_chunk #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .clk(clk), .rst_n(rst_n), .cur_i(cur_q), .lim_i(lim_q), .chunk_end_o(chunk_end)
  );

  function automatic st_e entry_st(logic more, op_e op, logic wt);
    st_e s;
    if (!more) s = S_DONE;
    else begin
      case (op)
        OP_INV:   s = S_INV;
        OP_CLEAN: s = wt ? S_DONE : S_CLN;
        default:  s = wt ? S_INV : S_CLN;
      endcase
    end
    return s;
  endfunction

  assign take   = cmd_valid && cmd_ready;
  assign upd_en = ((state_q == S_IDLE) && req_valid) || take || (state_q == S_DONE);

  // next state
  always_comb begin
    state_nx = state_q;
    cur_nx   = cur_q;
    lim_nx   = lim_q;
    op_nx    = op_q;
    wt_nx    = wt_q;
    tail_nx  = tail_q;
    case (state_q)
      S_IDLE: if (req_valid) begin
        cur_nx   = al_cur;
        lim_nx   = al_lim;
        op_nx    = in_op;
        wt_nx    = wt_override;
        tail_nx  = al_tail;
        state_nx = al_head ? S_HEAD :
                   al_tail ? S_TAIL : entry_st(al_cur < al_lim, in_op, wt_override);
      end
      S_HEAD: if (take)
        state_nx = tail_q ? S_TAIL : entry_st(cur_q < lim_q, op_q, wt_q);
      S_TAIL: if (take)
        state_nx = entry_st(cur_q < lim_q, op_q, wt_q);
      S_CLN: if (take) begin
        if (op_q == OP_INV || op_q == OP_CLEAN) begin
          cur_nx   = chunk_end;
          state_nx = entry_st(chunk_end < lim_q, op_q, wt_q);
        end else begin
          state_nx = S_INV;
        end
      end
      S_INV: if (take) begin
        cur_nx   = chunk_end;
        state_nx = entry_st(chunk_end < lim_q, op_q, wt_q);
      end
      default: state_nx = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      lim_q   <= '0;
      op_q    <= OP_INV;
      wt_q    <= 1'b0;
      tail_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_nx;
      cur_q   <= cur_nx;
      lim_q   <= lim_nx;
      op_q    <= op_nx;
      wt_q    <= wt_nx;
      tail_q  <= tail_nx;
    end
  end

  // outputs
  always_comb begin
    req_ready = (state_q == S_IDLE);
    done      = (state_q == S_DONE);
    cmd_valid = 1'b0;
    cmd_kind  = K_LINE;
    cmd_start = cur_q;
    cmd_end   = cur_q;
    case (state_q)
      S_HEAD: begin
        cmd_valid = 1'b1;
        cmd_start = cur_q - LINE;
        cmd_end   = cur_q - LINE;
      end
      S_TAIL: begin
        cmd_valid = 1'b1;
        cmd_start = lim_q;
        cmd_end   = lim_q;
      end
      S_CLN: begin
        cmd_valid = 1'b1;
        cmd_kind  = K_CLEAN;
        cmd_end   = chunk_end - LINE;
      end
      S_INV: begin
        cmd_valid = 1'b1;
        cmd_kind  = K_INV;
        cmd_end   = chunk_end - LINE;
      end
      default: ;
    endcase
  end

  // R13
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_start) && $stable(cmd_end) && $stable(cmd_kind));

  // R5
  same_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start >> PSH) == (cmd_end >> PSH));

  // R4
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_end - cmd_start) <= ADDR_W'(MAX_BYTES - LINE_BYTES));

  // R3
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[LSB-1:0] == '0) && (cmd_end[LSB-1:0] == '0) && (cmd_end >= cmd_start));

  // R10
  wt_no_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && wt_q |-> cmd_kind != K_CLEAN);

  // R12
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (cmd_valid || done)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready && !done);

  // R9
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cmd_kind == K_CLEAN && (op_q == OP_FLUSH || op_q == OP_FLUSH_ALT)
      |=> cmd_valid && cmd_kind == K_INV && $stable(cmd_start) && $stable(cmd_end));
endmodule

// File: tb/sim_rsplit_top.sv
module sim_rsplit_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, wt_override;
  logic [31:0] req_start, req_end;
  logic [1:0]  req_op;
  logic        cmd_valid, cmd_ready, done;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_start, cmd_end;

  int checks = 0, failures = 0, cycles = 0;
  bit wd_hit = 0;

  int          q_kind[$];
  logic [31:0] q_s[$], q_e[$];

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  rsplit_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_start(req_start), .req_end(req_end), .req_op(req_op), .wt_override(wt_override),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint cend(longint s, longint e);
    longint r = e;
    if (r > s + 1024) r = s + 1024;
    if (r > ((s | 4095) + 1)) r = (s | 4095) + 1;
    return r;
  endfunction

  function automatic void push(int k, longint s, longint e);
    q_kind.push_back(k);
    q_s.push_back(32'(s));
    q_e.push_back(32'(e));
  endfunction

  // behavioural expectation, kinds: 0 line, 1 clean, 2 invalidate
  function automatic void model(longint s, longint e, int op, bit w);
    longint r;
    if (op == 0) begin
      if (s % 32 != 0) begin
        push(0, s & ~longint'(31), s & ~longint'(31));
        s = (s | 31) + 1;
      end
      if (s < e && (e % 32 != 0)) begin
        push(0, e & ~longint'(31), e & ~longint'(31));
        e = e & ~longint'(31);
      end
      while (s < e) begin
        r = cend(s, e);
        push(2, s, r - 32);
        s = r;
      end
    end else begin
      s = s & ~longint'(31);
      e = (e + 31) & ~longint'(31);
      while (s < e) begin
        r = cend(s, e);
        if (!w) push(1, s, r - 32);
        if (op != 1) push(2, s, r - 32);
        s = r;
      end
    end
  endfunction

  function automatic bit rdy(int cyc, int pat);
    case (pat)
      0: return 1'b1;
      1: return cyc[0];
      default: return ((cyc * 7 + 3) % 3) != 0;
    endcase
  endfunction

  task automatic run(input logic [31:0] s, input logic [31:0] e, input int op,
                     input bit w, input int pat, input bit poke, input string tag);
    int cyc = 0;
    bit fin = 0, prev_pop, hold = 0;
    logic [1:0]  h_k;
    logic [31:0] h_s, h_e;
    int k;
    logic [31:0] es, ee;
    q_kind.delete(); q_s.delete(); q_e.delete();
    model(longint'(s), longint'(e), op, w);
    prev_pop = (q_kind.size() == 0);
    @(negedge clk);
    req_start = s; req_end = e; req_op = 2'(op); wt_override = w; req_valid = 1'b1;
    #1 chk(req_ready === 1'b1, "R12", {tag, " idle ready"}, req_ready, 1);
    @(negedge clk);
    if (poke) begin
      req_start = 32'h0000_5000; req_end = 32'h0000_7000; req_op = 2'd1;
    end else req_valid = 1'b0;
    while (!fin && !wd_hit) begin
      cmd_ready = rdy(cyc, pat);
      #1;
      chk(req_ready === 1'b0, "R12", {tag, " busy ready"}, req_ready, 0);
      if (hold) begin
        chk(cmd_valid === 1'b1 && cmd_kind == h_k && cmd_start == h_s && cmd_end == h_e,
            "R13", {tag, " stalled command held"}, cmd_start, h_s);
        hold = 0;
      end
      if (done === 1'b1) begin
        chk(q_kind.size() == 0 && prev_pop, "R11", {tag, " done timing"},
            q_kind.size(), 0);
        fin = 1;
        req_valid = 1'b0;
      end else if (cmd_valid === 1'b1) begin
        if (cmd_ready) begin
          if (q_kind.size() == 0) begin
            chk(0, "R2", {tag, " extra command"}, cmd_start, 0);
          end else begin
            k = q_kind.pop_front(); es = q_s.pop_front(); ee = q_e.pop_front();
            chk(int'(cmd_kind) == k, "R2", {tag, " kind"}, cmd_kind, k);
            chk(cmd_start == es, "R3", {tag, " start"}, cmd_start, es);
            chk(cmd_end == ee, "R4", {tag, " end"}, cmd_end, ee);
          end
          prev_pop = (q_kind.size() == 0);
        end else begin
          hold = 1; h_k = cmd_kind; h_s = cmd_start; h_e = cmd_end;
          prev_pop = 0;
        end
      end else begin
        chk(0, "R11", {tag, " neither command nor done"}, 0, 1);
        prev_pop = 0;
      end
      cyc++;
      if (!fin) @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_start = '0; req_end = '0; req_op = '0;
    wt_override = 1'b0; cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1",
        "in reset", {cmd_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1",
        "after reset", {cmd_valid, done}, 0);

    run(32'h1000, 32'h1400, 0, 0, 0, 0, "R4 inv aligned");
    run(32'h1010, 32'h1850, 0, 0, 1, 0, "R6 R7 inv unaligned");
    run(32'h0F00, 32'h1100, 1, 0, 0, 0, "R5 clean page cross");
    run(32'h2008, 32'h2901, 2, 0, 2, 0, "R8 R9 flush");
    run(32'h0FE4, 32'h1804, 2, 0, 1, 1, "R9 R12 flush with poke");
    run(32'h2000, 32'h2800, 1, 1, 0, 0, "R10 clean override");
    run(32'h2010, 32'h2C00, 2, 1, 1, 0, "R10 flush override");
    run(32'h3000, 32'h3000, 1, 0, 0, 0, "R11 empty clean");
    run(32'h3000, 32'h3000, 0, 0, 0, 0, "R11 empty inv");
    run(32'h0010, 32'h0018, 0, 0, 0, 0, "R6 inv inside one line");
    run(32'h0100, 32'h0130, 0, 0, 2, 0, "R7 inv partial tail");
    run(32'h0000, 32'h3000, 1, 0, 2, 0, "R4 R5 long clean");
    run(32'h4FF0, 32'h5000, 3, 0, 0, 0, "R2 op3 flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    wd_hit = 1;
    chk(0, "R11", "watchdog expired", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule